// File: doc/BRIEF.md
# Latched Interval Timer with Waveform Output

This block is a 16-bit down-counting interval timer behind a byte-wide register port with four addresses. Software places the next period in two 8-bit reload latches. A write to the counter-high address starts a countdown. The counter steps down once for each cycle in which `tick_en` is high. A time-out happens on the tick that carries the count from zero to all-ones.

Two mode inputs set the behaviour. In one-shot mode a time-out raises the interrupt flag once per start, and the counter then keeps wrapping and counting. In free-running mode every time-out reloads the whole counter from the latches, so the latches can be rewritten at any time to define the next period without disturbing the count in progress. A waveform output goes low when a countdown starts. In one-shot mode it returns high at time-out, which makes a single pulse of programmed width. In free-running mode it inverts at every time-out, which makes a square wave. While the waveform is enabled, the pin output-enable is forced on whatever the port direction bit says.

Top module: `interval_timer`

## Requirements
- R1: After a synchronous reset the flag is 0, `wave_out` is 1, and reads at all four addresses return 0.
- R2: A write at address 0 (counter low) or address 2 (latch low) stores the byte in the low latch only. The counter keeps its value.
- R3: A write at address 1 (counter high) sets the high latch to the written byte and loads the counter with {written byte, low latch}. It also clears the flag, arms the one-shot and drives `wave_out` low. When it falls in the same cycle as a tick, the load takes precedence.
- R4: A write at address 3 (latch high) updates only the high latch and clears the flag. The count in progress is not touched.
- R5: A read returns data on `bus_rdata` in the cycle after the strobe. Address 0 gives the counter low byte and clears the flag. Address 1 gives the counter high byte, address 2 the low latch and address 3 the high latch, with no side effect.
- R6: The counter decrements by one on each `tick_en` cycle. A tick at count 0 is a time-out.
- R7: In one-shot mode (`free_run`=0) the flag sets at the first time-out after an address-1 write and at no later time-out. The counter wraps to all-ones and keeps counting.
- R8: In one-shot mode `wave_out` stays low from the address-1 write until the first time-out, then goes high.
- R9: In free-running mode (`free_run`=1) each time-out reloads the counter from {high latch, low latch}, sets the flag and inverts `wave_out`.
- R10: `pin_oe` is 1 whenever `wave_en` is 1, and otherwise follows `port_dir`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable; one decrement per high cycle |
| free_run | input | 1 | 1 = free-running with reload, 0 = one-shot |
| wave_en | input | 1 | Enables the waveform onto the output pin |
| port_dir | input | 1 | Port direction bit for the shared pin |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address (0..3) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_flag | output | 1 | Time-out flag |
| wave_out | output | 1 | Pulse / square-wave level |
| pin_oe | output | 1 | Output enable for the shared pin |

## Verification
The one-shot run loads a short period, reads back every address and counts through the first time-out. It then counts through a full 65536-tick wrap, which separates a flag that re-arms itself from one that needs a fresh start. The free-running pattern checks that the reload takes the latch value and not all-ones, and that the waveform toggles instead of settling high. A latch rewrite made mid-count must leave the current count intact and shape only the next period. Checks on `pin_oe` and the reset state cover the remaining combinations.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  typedef enum logic [1:0] {
    A_CNT_LO = 2'd0,
    A_CNT_HI = 2'd1,
    A_LAT_LO = 2'd2,
    A_LAT_HI = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/itmr_regs.sv
module itmr_regs
  import itmr_pkg::*;
#(
  parameter int HALF_W = 8,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [HALF_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  lat,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic              clr,
  output logic [HALF_W-1:0] rdata
);
  reg_addr_e ra;
  logic [1:0] lane_we;

  assign ra = reg_addr_e'(addr);
  assign lane_we[0] = sel && wr && (ra == A_CNT_LO || ra == A_LAT_LO);
  assign lane_we[1] = sel && wr && (ra == A_CNT_HI || ra == A_LAT_HI);

  // One byte lane per latch half
  for (genvar h = 0; h < 2; h++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)             lat[h*HALF_W +: HALF_W] <= '0;
      else if (lane_we[h]) lat[h*HALF_W +: HALF_W] <= wdata;
    end
  end

  assign load     = sel && wr && (ra == A_CNT_HI);
  assign load_val = {wdata, lat[HALF_W-1:0]};
  assign clr      = sel && ((wr && ra == A_LAT_HI) || (!wr && ra == A_CNT_LO));

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (sel && !wr) begin
      unique case (ra)
        A_CNT_LO: rdata <= cnt[HALF_W-1:0];
        A_CNT_HI: rdata <= cnt[CNT_W-1:HALF_W];
        A_LAT_LO: rdata <= lat[HALF_W-1:0];
        A_LAT_HI: rdata <= lat[CNT_W-1:HALF_W];
      endcase
    end
  end
endmodule

// File: rtl/itmr_core.sv
module itmr_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             free_run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clr,
  input  logic [CNT_W-1:0] lat,
  output logic [CNT_W-1:0] cnt,
  output logic             flag,
  output logic             wave
);
  logic armed;
  logic at_zero, expire, fire;

  assign at_zero = (cnt == '0);
  assign expire  = tick && at_zero;
  assign fire    = expire && (free_run || armed);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      flag  <= 1'b0;
      armed <= 1'b0;
      wave  <= 1'b1;
    end else if (load) begin
      cnt   <= load_val;
      flag  <= 1'b0;
      armed <= 1'b1;
      wave  <= 1'b0;
    end else begin
      if (tick) begin
        if (at_zero && free_run) cnt <= lat;
        else                     cnt <= cnt - 1'b1;
      end
      if (fire) begin
        flag <= 1'b1;
        if (free_run) begin
          wave <= ~wave;
        end else begin
          wave  <= 1'b1;
          armed <= 1'b0;
        end
      end else if (clr) begin
        flag <= 1'b0;
      end
    end
  end

  // R3
  load_start_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (!flag && !wave && cnt == $past(load_val)));

  // R6
  step_down_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && !at_zero) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

  // R7
  flag_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(tick && at_zero && (armed || free_run)));

  // R8
  pulse_end_chk: assert property (@(posedge clk) disable iff (rst)
    (expire && !free_run && armed && !load) |=> (wave && flag));

  // R9
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (expire && free_run && !load) |=> (cnt == $past(lat) && flag && wave != $past(wave)));
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int HALF_W = 8,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              free_run,
  input  logic              wave_en,
  input  logic              port_dir,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata,
  output logic              irq_flag,
  output logic              wave_out,
  output logic              pin_oe
);
  logic [CNT_W-1:0] cnt, lat, load_val;
  logic             load, clr;

  itmr_regs #(.HALF_W(HALF_W)) u_regs (
    .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .cnt(cnt), .lat(lat), .load(load),
    .load_val(load_val), .clr(clr), .rdata(bus_rdata)
  );

  itmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick_en), .free_run(free_run),
    .load(load), .load_val(load_val), .clr(clr), .lat(lat),
    .cnt(cnt), .flag(irq_flag), .wave(wave_out)
  );

  assign pin_oe = wave_en | port_dir;

  // R4
  latch_hi_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_addr == 2'd3 && !(tick_en && cnt == '0))
      |=> (!irq_flag && cnt == CNT_W'($past(cnt) - $past(tick_en))));
endmodule

// File: tb/interval_timer_tb.sv
`timescale 1ns/1ps
module interval_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0, free_run = 1'b0, wave_en = 1'b1, port_dir = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_flag, wave_out, pin_oe;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  interval_timer u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .free_run(free_run),
    .wave_en(wave_en), .port_dir(port_dir), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_flag(irq_flag), .wave_out(wave_out),
    .pin_oe(pin_oe)
  );

  // {kind[3:0], req[3:0], addr[3:0], data[15:0]}; kind 0 write, 1 read, 2 ticks, 3 {flag,wave}
  localparam int NV = 19;
  localparam logic [27:0] VEC [NV] = '{
    {4'd0, 4'd2, 4'd2, 16'h0005},
    {4'd0, 4'd3, 4'd1, 16'h0000},
    {4'd1, 4'd2, 4'd2, 16'h0005},
    {4'd1, 4'd3, 4'd1, 16'h0000},
    {4'd1, 4'd3, 4'd0, 16'h0005},
    {4'd2, 4'd6, 4'd0, 16'd5},
    {4'd3, 4'd8, 4'd0, 16'h0000},
    {4'd2, 4'd6, 4'd0, 16'd1},
    {4'd3, 4'd8, 4'd0, 16'h0003},
    {4'd1, 4'd6, 4'd1, 16'h00FF},
    {4'd1, 4'd5, 4'd3, 16'h0000},
    {4'd2, 4'd6, 4'd0, 16'd2},
    {4'd3, 4'd7, 4'd0, 16'h0003},
    {4'd1, 4'd5, 4'd0, 16'h00FD},
    {4'd3, 4'd5, 4'd0, 16'h0001},
    {4'd2, 4'd7, 4'd0, 16'hFFFE},
    {4'd3, 4'd7, 4'd0, 16'h0001},
    {4'd1, 4'd7, 4'd1, 16'h00FF},
    {4'd1, 4'd7, 4'd0, 16'h00FF}
  };

  task automatic check(input int req, input int got, input int exp, input string what);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick_en = 1;
    repeat (n) @(negedge clk);
    tick_en = 0;
  endtask

  task automatic read_chk(input int req, input logic [1:0] a, input logic [7:0] e);
    logic [7:0] d;
    bus_read(a, d);
    check(req, d, e, $sformatf("read addr %0d", a));
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R6 watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    @(negedge clk);
    check(1, irq_flag, 0, "flag after reset");
    check(1, wave_out, 1, "wave after reset");
    for (int a = 0; a < 4; a++) read_chk(1, 2'(a), 8'h00);

    // One-shot table walk (R2 R3 R5 R6 R7 R8)
    for (int i = 0; i < NV; i++) begin
      logic [3:0] k, rq, ad;
      logic [15:0] dv;
      {k, rq, ad, dv} = VEC[i];
      case (k)
        4'd0: bus_write(ad[1:0], dv[7:0]);
        4'd1: read_chk(rq, ad[1:0], dv[7:0]);
        4'd2: ticks(dv);
        default: begin
          check(rq, irq_flag, dv[1], $sformatf("vec %0d flag", i));
          check(rq, wave_out, dv[0], $sformatf("vec %0d wave", i));
        end
      endcase
    end

    // R9 free-running reload, flag and toggle
    free_run = 1;
    bus_write(2'd2, 8'h03);
    bus_write(2'd3, 8'h00);
    bus_write(2'd1, 8'h00);
    ticks(4);
    check(9, irq_flag, 1, "free-run flag");
    check(9, wave_out, 1, "free-run first toggle");
    read_chk(9, 2'd0, 8'h03);
    read_chk(9, 2'd1, 8'h00);
    ticks(4);
    check(9, irq_flag, 1, "free-run second flag");
    check(9, wave_out, 0, "free-run second toggle");
    // R4 latch-high write clears flag, count untouched
    bus_write(2'd3, 8'h00);
    check(4, irq_flag, 0, "flag after latch-high write");
    read_chk(4, 2'd0, 8'h03);
    // R2 counter-low address write goes to latch only
    bus_write(2'd0, 8'h02);
    read_chk(2, 2'd2, 8'h02);
    read_chk(2, 2'd0, 8'h03);
    ticks(4);
    read_chk(9, 2'd0, 8'h02);
    check(9, wave_out, 1, "free-run third toggle");

    // R3 load wins over a tick at zero in the same cycle
    ticks(2);
    @(negedge clk); tick_en = 1; bus_sel = 1; bus_wr = 1; bus_addr = 2'd1; bus_wdata = 8'h12;
    @(negedge clk); tick_en = 0; bus_sel = 0; bus_wr = 0;
    check(3, irq_flag, 0, "flag after load over tick");
    check(3, wave_out, 0, "wave after load over tick");
    read_chk(3, 2'd1, 8'h12);
    read_chk(3, 2'd0, 8'h02);

    // R10 output enable
    wave_en = 1; port_dir = 0; #1;
    check(10, pin_oe, 1, "oe with wave enabled");
    wave_en = 0; port_dir = 0; #1;
    check(10, pin_oe, 0, "oe with both off");
    port_dir = 1; #1;
    check(10, pin_oe, 1, "oe from direction bit");

    finish_run();
  end
endmodule